// File: doc/BRIEF.md
# Byte-Serial Cursor and Border Color Bank

This block holds four 24-bit colors: the border (overscan) color and three cursor colors. A host reaches them through a byte-wide register port with a 4-bit register select. To store colors, the host first loads a write pointer that chooses a starting color. It then sends bytes to a shared data offset in the order red, green, blue. Reading works the same way through a separate read pointer. Each pointer moves to the next color once the blue byte has been moved. The host can therefore fill or dump the whole bank with one pointer write followed by twelve data accesses.

All four colors are driven out in parallel to the cursor and border drawing logic. Red and green bytes wait in staging registers. A color changes in a single cycle, when its blue byte arrives, so downstream logic never sees a half-written color.

Top module: `aux_color_bank`

## Requirements
- R1: After synchronous reset, all four colors are zero and `rdata` is zero. Both pointers select color 0 and both byte phases are red.
- R2: Register offsets: 4'h4 loads the write pointer, 4'h5 is the color data port and 4'h7 loads the read pointer. A write or read to any other offset changes no color, pointer, byte phase or `rdata`.
- R3: A pointer is loaded from `wdata[1:0]`, and `wdata[7:2]` is ignored. The value selects a color: 0 is the border color (`colors_o[0]`), 1 is cursor color 0, 2 is cursor color 1 and 3 is cursor color 2.
- R4: Three data-port writes deliver red, green and blue. One cycle after the blue write, the selected color reads {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R5: A red or green data write leaves every color output unchanged.
- R6: After a blue write, the write pointer steps to the next color. It wraps from 3 to 0.
- R7: A data-port read loads `rdata` on the next cycle with the red, green or blue byte of the color at the read pointer. The byte follows the read phase. After the blue read, the read pointer steps to the next color and wraps from 3 to 0.
- R8: One pointer load followed by twelve data accesses transfers all four colors, starting from any pointer value.
- R9: Loading either pointer returns both byte phases to red. The other pointer's value is left unchanged.
- R10: `rdata` holds its value in every cycle without a data-port read.
- R11: A data-port read and write in the same cycle are both carried out, each on its own pointer and phase. The read returns the color as it was committed before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 4 | Register offset of the access |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rd_en | input | 1 | Read strobe, one access per cycle high |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, registered |
| colors_o | output | 4x24 | All four colors; index 0 is the border color, 1..3 the cursor colors |

## Verification
Assertions watch several rules on every cycle. The byte phase only takes legal values, and any pointer load forces it back to red. A pointer steps by exactly one only on a blue access. Colors stay frozen outside a blue write, and `rdata` holds when there is no data read. A loaded pointer equals the low bits of the byte written. The bench scenarios are needed to show that the byte values land in the right color and field, and that the twelve-access sweep wraps and covers the bank. They also show that accesses at unused offsets leave a half-finished sequence intact, and that a read and a write in the same cycle see the expected committed data.

// File: rtl/aux_color_pkg.sv
package aux_color_pkg;

    parameter int BYTE_W     = 8;
    parameter int NUM_COLORS = 4;
    parameter int SEL_W      = 4;

    localparam int PTR_W   = $clog2(NUM_COLORS);
    localparam int COLOR_W = 3 * BYTE_W;

    localparam logic [SEL_W-1:0] OFS_WPTR = 4'h4;
    localparam logic [SEL_W-1:0] OFS_DATA = 4'h5;
    localparam logic [SEL_W-1:0] OFS_RPTR = 4'h7;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_t;

    typedef struct packed {
        logic [BYTE_W-1:0] red;
        logic [BYTE_W-1:0] green;
        logic [BYTE_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic wptr_load;
        logic rptr_load;
        logic data_wr;
        logic data_rd;
    } host_op_t;

    function automatic phase_t phase_after(phase_t p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(rgb_t c, phase_t p);
        case (p)
            PH_RED:   return c.red;
            PH_GREEN: return c.green;
            default:  return c.blue;
        endcase
    endfunction

endpackage

// File: rtl/aux_color_decode.sv
module aux_color_decode
    import aux_color_pkg::*;
(
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    output host_op_t         op
);

    always_comb begin
        op           = '0;
        op.wptr_load = wr_en && (reg_sel == OFS_WPTR);
        op.rptr_load = wr_en && (reg_sel == OFS_RPTR);
        op.data_wr   = wr_en && (reg_sel == OFS_DATA);
        op.data_rd   = rd_en && (reg_sel == OFS_DATA);
    end

endmodule

// File: rtl/aux_color_seq.sv
module aux_color_seq
    import aux_color_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             restart,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output phase_t           phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            phase <= PH_RED;
        end else if (load) begin
            ptr   <= load_val;
            phase <= PH_RED;
        end else if (restart) begin
            phase <= PH_RED;
        end else if (step) begin
            phase <= phase_after(phase);
            if (phase == PH_BLUE)
                ptr <= ptr + 1'b1;
        end
    end

    // R7
    phase_legal_chk: assert property (@(posedge clk) disable iff (rst)
        phase != 2'b11);

    // R9
    restart_red_chk: assert property (@(posedge clk) disable iff (rst)
        (load || restart) |=> phase == PH_RED);

    // R6
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !restart && phase == PH_BLUE)
        |=> ptr == PTR_W'($past(ptr) + 1'b1));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !(step && phase == PH_BLUE)) |=> $stable(ptr));

endmodule

// File: rtl/aux_color_store.sv
module aux_color_store
    import aux_color_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_step,
    input  phase_t                  wr_phase,
    input  logic [PTR_W-1:0]        wr_ptr,
    input  logic [BYTE_W-1:0]       wdata,
    output rgb_t [NUM_COLORS-1:0]   colors
);

    logic [BYTE_W-1:0] stage_red;
    logic [BYTE_W-1:0] stage_green;
    logic              commit;

    assign commit = wr_step && (wr_phase == PH_BLUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_red   <= '0;
            stage_green <= '0;
        end else if (wr_step) begin
            if (wr_phase == PH_RED)
                stage_red <= wdata;
            if (wr_phase == PH_GREEN)
                stage_green <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_COLORS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                colors[i] <= '0;
            else if (commit && (wr_ptr == PTR_W'(i)))
                colors[i] <= '{red: stage_red, green: stage_green, blue: wdata};
        end
    end

    // R5
    no_partial_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(colors));

endmodule

// File: rtl/aux_color_rdport.sv
module aux_color_rdport
    import aux_color_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_step,
    input  phase_t                  rd_phase,
    input  logic [PTR_W-1:0]        rd_ptr,
    input  rgb_t [NUM_COLORS-1:0]   colors,
    output logic [BYTE_W-1:0]       rdata
);

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_step)
            rdata <= pick_byte(colors[rd_ptr], rd_phase);
    end

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_step |=> $stable(rdata));

endmodule

// File: rtl/aux_color_bank.sv
module aux_color_bank
    import aux_color_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [SEL_W-1:0]                     reg_sel,
    input  logic                                 wr_en,
    input  logic                                 rd_en,
    input  logic [BYTE_W-1:0]                    wdata,
    output logic [BYTE_W-1:0]                    rdata,
    output logic [NUM_COLORS-1:0][COLOR_W-1:0]   colors_o
);

    host_op_t               op;
    logic                   any_load;
    logic [PTR_W-1:0]       wr_ptr;
    logic [PTR_W-1:0]       rd_ptr;
    phase_t                 wr_phase;
    phase_t                 rd_phase;
    rgb_t [NUM_COLORS-1:0]  colors;

    assign any_load = op.wptr_load || op.rptr_load;

    aux_color_decode u_decode (
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .op      (op)
    );

    aux_color_seq u_wseq (
        .clk      (clk),
        .rst      (rst),
        .load     (op.wptr_load),
        .load_val (wdata[PTR_W-1:0]),
        .restart  (any_load),
        .step     (op.data_wr),
        .ptr      (wr_ptr),
        .phase    (wr_phase)
    );

    aux_color_seq u_rseq (
        .clk      (clk),
        .rst      (rst),
        .load     (op.rptr_load),
        .load_val (wdata[PTR_W-1:0]),
        .restart  (any_load),
        .step     (op.data_rd),
        .ptr      (rd_ptr),
        .phase    (rd_phase)
    );

    aux_color_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_step  (op.data_wr),
        .wr_phase (wr_phase),
        .wr_ptr   (wr_ptr),
        .wdata    (wdata),
        .colors   (colors)
    );

    aux_color_rdport u_rdport (
        .clk      (clk),
        .rst      (rst),
        .rd_step  (op.data_rd),
        .rd_phase (rd_phase),
        .rd_ptr   (rd_ptr),
        .colors   (colors),
        .rdata    (rdata)
    );

    for (genvar i = 0; i < NUM_COLORS; i++) begin : g_out
        assign colors_o[i] = colors[i];
    end

    // R3
    wptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        op.wptr_load |=> wr_ptr == $past(wdata[PTR_W-1:0]));

    // R3
    rptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        op.rptr_load |=> rd_ptr == $past(wdata[PTR_W-1:0]));

    // R9
    rptr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op.wptr_load && !op.data_rd) |=> $stable(rd_ptr));

endmodule

// File: tb/aux_color_bank_tb.sv
module aux_color_bank_tb_top;
    import aux_color_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 26;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [3:0] sel;
        logic [7:0] d;
        logic [7:0] exp;
    } vec_t;

    // sweep: load write pointer 2, write 12 bytes (colors 2,3,0,1), then read back
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 4'h4, 8'h02, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h21, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h22, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h23, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h31, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h32, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h33, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h01, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h02, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h03, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h11, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h12, 8'h00},
        '{1'b1, 1'b0, 4'h5, 8'h13, 8'h00},
        '{1'b1, 1'b0, 4'h7, 8'h02, 8'h00},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h21},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h22},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h23},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h31},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h32},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h33},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h01},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h02},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h03},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h11},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h12},
        '{1'b0, 1'b1, 4'h5, 8'h00, 8'h13}
    };

    logic                                clk = 1'b0;
    logic                                rst = 1'b1;
    logic [SEL_W-1:0]                    reg_sel = '0;
    logic                                wr_en = 1'b0;
    logic                                rd_en = 1'b0;
    logic [BYTE_W-1:0]                   wdata = '0;
    logic [BYTE_W-1:0]                   rdata;
    logic [NUM_COLORS-1:0][COLOR_W-1:0]  colors_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_color_bank dut_i (
        .clk      (clk),
        .rst      (rst),
        .reg_sel  (reg_sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .colors_o (colors_o)
    );

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %06h expected %06h", req, act, exp);
        end
    endtask

    task automatic access(logic wr, logic rd, logic [3:0] sel, logic [7:0] d);
        @(negedge clk);
        wr_en   = wr;
        rd_en   = rd;
        reg_sel = sel;
        wdata   = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic wr(logic [3:0] sel, logic [7:0] d);
        access(1'b1, 1'b0, sel, d);
    endtask

    task automatic rd_data();
        access(1'b0, 1'b1, 4'h5, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < NUM_COLORS; i++)
            check("R1 color after reset", colors_o[i], 24'h0);
        check("R1 rdata after reset", {16'h0, rdata}, 24'h0);

        // R8 / R7 table sweep starting at color 2
        for (int k = 0; k < NVEC; k++) begin
            access(VEC[k].wr, VEC[k].rd, VEC[k].sel, VEC[k].d);
            if (VEC[k].rd)
                check("R7 R8 sweep read", {16'h0, rdata}, {16'h0, VEC[k].exp});
        end
        check("R8 color0", colors_o[0], 24'h010203);
        check("R8 color1", colors_o[1], 24'h111213);
        check("R8 color2", colors_o[2], 24'h212223);
        check("R8 color3", colors_o[3], 24'h313233);

        // R2 / R10 unused offset write
        wr(4'h6, 8'h55);
        check("R10 rdata hold", {16'h0, rdata}, 24'h000013);
        check("R2 unused offset color0", colors_o[0], 24'h010203);

        // R5 / R4 / R6
        wr(4'h4, 8'h01);
        wr(4'h5, 8'hAA);
        check("R5 after red", colors_o[1], 24'h111213);
        wr(4'h5, 8'hBB);
        check("R5 after green", colors_o[1], 24'h111213);
        wr(4'h5, 8'hCC);
        check("R4 commit on blue", colors_o[1], 24'hAABBCC);
        wr(4'h5, 8'h44); wr(4'h5, 8'h45); wr(4'h5, 8'h46);
        check("R6 pointer advance", colors_o[2], 24'h444546);

        // R6 wrap 3 -> 0
        wr(4'h4, 8'h03);
        wr(4'h5, 8'h61); wr(4'h5, 8'h62); wr(4'h5, 8'h63);
        wr(4'h5, 8'h71); wr(4'h5, 8'h72); wr(4'h5, 8'h73);
        check("R6 wrap color3", colors_o[3], 24'h616263);
        check("R6 wrap color0", colors_o[0], 24'h717273);

        // R3 upper pointer bits ignored: 0xFE selects color 2
        wr(4'h4, 8'hFE);
        wr(4'h5, 8'h81); wr(4'h5, 8'h82); wr(4'h5, 8'h83);
        check("R3 upper bits ignored", colors_o[2], 24'h818283);
        check("R3 neighbour untouched", colors_o[3], 24'h616263);

        // R2 unused offsets do not disturb a half-done sequence
        wr(4'h4, 8'h00);
        wr(4'h5, 8'h91);
        wr(4'h6, 8'hEE);
        wr(4'h3, 8'hEE);
        access(1'b0, 1'b1, 4'h4, 8'h00);
        check("R2 read of pointer offset keeps rdata", {16'h0, rdata}, 24'h000013);
        wr(4'h5, 8'h92); wr(4'h5, 8'h93);
        check("R2 sequence intact", colors_o[0], 24'h919293);

        // R9 read-pointer load restarts write phase, keeps write pointer
        wr(4'h4, 8'h00);
        wr(4'h5, 8'h5A);
        wr(4'h7, 8'h01);
        wr(4'h5, 8'h0A); wr(4'h5, 8'h0B); wr(4'h5, 8'h0C);
        check("R9 write phase restarted", colors_o[0], 24'h0A0B0C);
        rd_data(); check("R7 read red", {16'h0, rdata}, 24'h0000AA);
        rd_data(); check("R7 read green", {16'h0, rdata}, 24'h0000BB);
        rd_data(); check("R7 read blue", {16'h0, rdata}, 24'h0000CC);
        rd_data(); check("R7 next color red", {16'h0, rdata}, 24'h000081);
        wr(4'h4, 8'h00);
        rd_data(); check("R9 read phase restarted", {16'h0, rdata}, 24'h000081);
        rd_data(); check("R9 then green", {16'h0, rdata}, 24'h000082);

        // R7 read wrap 3 -> 0
        wr(4'h7, 8'h03);
        rd_data(); rd_data(); rd_data();
        check("R7 color3 blue", {16'h0, rdata}, 24'h000063);
        rd_data();
        check("R7 wrap to color0", {16'h0, rdata}, 24'h00000A);

        // R11 simultaneous read and write
        wr(4'h4, 8'h01);
        wr(4'h7, 8'h01);
        access(1'b1, 1'b1, 4'h5, 8'hD1);
        check("R11 read red old", {16'h0, rdata}, 24'h0000AA);
        access(1'b1, 1'b1, 4'h5, 8'hD2);
        check("R11 read green old", {16'h0, rdata}, 24'h0000BB);
        access(1'b1, 1'b1, 4'h5, 8'hD3);
        check("R11 read blue old", {16'h0, rdata}, 24'h0000CC);
        check("R11 write committed", colors_o[1], 24'hD1D2D3);
        rd_data();
        check("R11 read advanced", {16'h0, rdata}, 24'h000081);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset clears color1", colors_o[1], 24'h0);
        check("R1 reset clears rdata", {16'h0, rdata}, 24'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule